// File: doc/BRIEF.md
# Shared-Pool Input Buffer with Per-Output Address Queues

This block is the input storage of one router port. Arriving flits are written into a single pool of flit slots. A slot is taken from a free-slot list when the flit arrives, so no output owns any fixed share of the storage. Each flit arrives with its output port already decided by the previous hop. The block appends the slot address to a small address queue kept for that output. Only addresses move through these queues, and the flit data stays in the pool until it is read out.

For every output the block presents the flit at the head of that output's queue, with a valid flag. A switch allocator can therefore see all candidate heads at once and read them without waiting on route computation. The allocator returns a grant on the `deq_grant` vector. In that same cycle the head slot is read, popped from its queue and handed back to the free list. A slot released this way can be taken by an incoming flit in the same cycle.

Top module: `voq_pool_buffer`

## Requirements
- R1: After reset every `head_valid` bit is 0, `in_ready` is 1 and all `DEPTH` slots are free.
- R2: A flit accepted (`in_valid` and `in_ready` both 1 at a clock edge) with `in_port` = p makes `head_valid[p]` 1 from the next cycle on. If queue p was empty, `head_data` slice p (bits p*DATA_W and up) then equals that flit's data.
- R3: Within one output queue, flits leave in the order in which they were accepted.
- R4: The queues are independent. Flits held for one output never hide or delay the head of another output.
- R5: `in_ready` is 0 only when no slot is free and no valid grant is present in that cycle. This holds however the stored flits are spread over the outputs, including all `DEPTH` slots held by one output.
- R6: At most one grant bit is set per cycle. When the pool is full, a grant on a valid head raises `in_ready` in that same cycle, and a flit offered then is accepted into the slot just released.
- R7: A grant on an output whose `head_valid` is 0 has no effect. It frees no slot and changes no queue.
- R8: The number of free slots plus the number of queued entries over all outputs always equals `DEPTH`. After any mix of traffic has drained, exactly `DEPTH` flits can be accepted again.
- R9: A grant on a valid head removes that head at the clock edge. The next cycle shows the following entry of that queue, or `head_valid` 0 if the queue is now empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming flit present |
| in_ready | output | 1 | A slot is available this cycle |
| in_data | input | DATA_W | Incoming flit payload |
| in_port | input | OUT_W | Output port chosen one hop earlier |
| deq_grant | input | NUM_OUT | One-hot-or-zero dequeue grant per output |
| head_valid | output | NUM_OUT | Queue for each output is non-empty |
| head_data | output | NUM_OUT*DATA_W | Head flit for each output, slice o at o*DATA_W |

## Verification
The bench first sends a burst to one output, then flits spread over every output. The burst separates per-queue ordering from mix-ups between queues. The spread shows whether all heads are visible at once. Next it fills the whole pool through one output, which tells a shared pool apart from fixed per-queue limits. While the pool is full it grants an empty queue, then a valid head together with a new arrival. These two cases isolate the same-cycle slot reuse from a grant that has to be ignored. A final drain followed by a refill over all outputs shows whether any slot was lost or counted twice.

// File: rtl/voq_pkg.sv
package voq_pkg;

   localparam int unsigned VOQ_MAX_OUT = 16;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/voq_free_list.sv
module voq_free_list #(
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   output logic [ADDR_W-1:0] take_addr,
   input  logic              give,
   input  logic [ADDR_W-1:0] give_addr,
   output logic [CNT_W-1:0]  free_cnt
);

   logic [ADDR_W-1:0] slots [DEPTH];
   logic [ADDR_W-1:0] rd_ptr;
   logic [ADDR_W-1:0] wr_ptr;
   logic              pass_through;

   // a slot released while the list is empty goes straight to the taker
   assign pass_through = take && give && (free_cnt == '0);
   assign take_addr    = (free_cnt == '0) ? give_addr : slots[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(DEPTH); i++) begin
            slots[i] <= ADDR_W'(i);
         end
         rd_ptr   <= '0;
         wr_ptr   <= '0;
         free_cnt <= CNT_W'(DEPTH);
      end else if (!pass_through) begin
         if (give) begin
            slots[wr_ptr] <= give_addr;
            wr_ptr        <= wr_ptr + 1'b1;
         end
         if (take) begin
            rd_ptr <= rd_ptr + 1'b1;
         end
         case ({give, take})
            2'b10:   free_cnt <= free_cnt + 1'b1;
            2'b01:   free_cnt <= free_cnt - 1'b1;
            default: free_cnt <= free_cnt;
         endcase
      end
   end

endmodule

// File: rtl/voq_addr_fifo.sv
module voq_addr_fifo #(
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [ADDR_W-1:0] push_addr,
   input  logic              pop,
   output logic [ADDR_W-1:0] head_addr,
   output logic [CNT_W-1:0]  count
);

   logic [ADDR_W-1:0] entries [DEPTH];
   logic [ADDR_W-1:0] rd_ptr;
   logic [ADDR_W-1:0] wr_ptr;

   assign head_addr = entries[rd_ptr];

   always_ff @(posedge clk) begin
      if (push) begin
         entries[wr_ptr] <= push_addr;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

endmodule

// File: rtl/voq_slot_pool.sv
module voq_slot_pool #(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned DEPTH   = 8,
   parameter int unsigned ADDR_W  = 3,
   parameter int unsigned NUM_OUT = 4
) (
   input  logic                        clk,
   input  logic                        wr_en,
   input  logic [ADDR_W-1:0]           wr_addr,
   input  logic [DATA_W-1:0]           wr_data,
   input  logic [NUM_OUT*ADDR_W-1:0]   rd_addr,
   output logic [NUM_OUT*DATA_W-1:0]   rd_data
);

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         cells[wr_addr] <= wr_data;
      end
   end

   for (genvar o = 0; o < NUM_OUT; o++) begin : g_rd
      assign rd_data[o*DATA_W +: DATA_W] = cells[rd_addr[o*ADDR_W +: ADDR_W]];
   end

endmodule

// File: rtl/voq_pool_buffer.sv
module voq_pool_buffer #(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned NUM_OUT = 4,
   parameter int unsigned DEPTH   = 8,
   localparam int unsigned OUT_W  = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1,
   localparam int unsigned ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   output logic                      in_ready,
   input  logic [DATA_W-1:0]         in_data,
   input  logic [OUT_W-1:0]          in_port,
   input  logic [NUM_OUT-1:0]        deq_grant,
   output logic [NUM_OUT-1:0]        head_valid,
   output logic [NUM_OUT*DATA_W-1:0] head_data
);

   import voq_pkg::*;

   if (!is_pow2(DEPTH) || DEPTH < 2) begin : g_bad_depth
      $error("voq_pool_buffer: DEPTH must be a power of two, at least 2");
   end
   if (NUM_OUT < 2 || NUM_OUT > VOQ_MAX_OUT) begin : g_bad_out
      $error("voq_pool_buffer: NUM_OUT out of range");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("voq_pool_buffer: DATA_W must be positive");
   end

   logic [NUM_OUT-1:0]        deq_fire;
   logic                      any_deq;
   logic [ADDR_W-1:0]         deq_addr;
   logic [ADDR_W-1:0]         alloc_addr;
   logic                      port_ok;
   logic                      enq;
   logic [CNT_W-1:0]          free_cnt;
   logic [NUM_OUT*CNT_W-1:0]  q_cnt_flat;
   logic [NUM_OUT*ADDR_W-1:0] head_addr_flat;

   assign deq_fire = deq_grant & head_valid;
   assign any_deq  = |deq_fire;
   assign port_ok  = (32'(in_port) < NUM_OUT);
   assign in_ready = (free_cnt != '0) || any_deq;
   assign enq      = in_valid && in_ready && port_ok;

   always_comb begin
      deq_addr = '0;
      for (int o = 0; o < int'(NUM_OUT); o++) begin
         if (deq_fire[o]) begin
            deq_addr = deq_addr | head_addr_flat[o*ADDR_W +: ADDR_W];
         end
      end
   end

   voq_free_list #(
      .DEPTH (DEPTH),
      .ADDR_W(ADDR_W),
      .CNT_W (CNT_W)
   ) u_free (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (enq),
      .take_addr(alloc_addr),
      .give     (any_deq),
      .give_addr(deq_addr),
      .free_cnt (free_cnt)
   );

   for (genvar o = 0; o < NUM_OUT; o++) begin : g_q
      logic [CNT_W-1:0] cnt;
      voq_addr_fifo #(
         .DEPTH (DEPTH),
         .ADDR_W(ADDR_W),
         .CNT_W (CNT_W)
      ) u_fifo (
         .clk      (clk),
         .rst_n    (rst_n),
         .push     (enq && (32'(in_port) == o)),
         .push_addr(alloc_addr),
         .pop      (deq_fire[o]),
         .head_addr(head_addr_flat[o*ADDR_W +: ADDR_W]),
         .count    (cnt)
      );
      assign q_cnt_flat[o*CNT_W +: CNT_W] = cnt;
      assign head_valid[o] = (cnt != '0);
   end

   voq_slot_pool #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH),
      .ADDR_W (ADDR_W),
      .NUM_OUT(NUM_OUT)
   ) u_pool (
      .clk    (clk),
      .wr_en  (enq),
      .wr_addr(alloc_addr),
      .wr_data(in_data),
      .rd_addr(head_addr_flat),
      .rd_data(head_data)
   );

endmodule

// File: rtl/voq_pool_checker.sv
module voq_pool_checker #(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned NUM_OUT = 4,
   parameter int unsigned DEPTH   = 8,
   parameter int unsigned OUT_W   = 2,
   parameter int unsigned CNT_W   = 4
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      in_valid,
   input logic                      in_ready,
   input logic [OUT_W-1:0]          in_port,
   input logic [NUM_OUT-1:0]        deq_grant,
   input logic [NUM_OUT-1:0]        head_valid,
   input logic [NUM_OUT*DATA_W-1:0] head_data,
   input logic [CNT_W-1:0]          free_cnt,
   input logic [NUM_OUT*CNT_W-1:0]  q_cnt_flat
);

   int unsigned total;
   always_comb begin
      total = 32'(free_cnt);
      for (int o = 0; o < int'(NUM_OUT); o++) begin
         total = total + 32'(q_cnt_flat[o*CNT_W +: CNT_W]);
      end
   end

   assert_slot_balance_R8: assert property (@(posedge clk) disable iff (!rst_n)
      total == DEPTH);

   assert_stall_only_when_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ready |-> (free_cnt == '0) && ((deq_grant & head_valid) == '0));

   assert_single_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(deq_grant));

   for (genvar o = 0; o < NUM_OUT; o++) begin : g_port
      assert_enq_shows_head_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_ready && (32'(in_port) == o)) |=> head_valid[o]);

      assert_head_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (head_valid[o] && !deq_grant[o]) |=>
            head_valid[o] && $stable(head_data[o*DATA_W +: DATA_W]));

      assert_empty_grant_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (!head_valid[o] && !(in_valid && in_ready && (32'(in_port) == o))) |=> !head_valid[o]);
   end

endmodule

bind voq_pool_buffer voq_pool_checker #(
   .DATA_W (DATA_W),
   .NUM_OUT(NUM_OUT),
   .DEPTH  (DEPTH),
   .OUT_W  (OUT_W),
   .CNT_W  (CNT_W)
) u_voq_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_port   (in_port),
   .deq_grant (deq_grant),
   .head_valid(head_valid),
   .head_data (head_data),
   .free_cnt  (free_cnt),
   .q_cnt_flat(q_cnt_flat)
);

// File: tb/tb_voq_pool_buffer.sv
`timescale 1ns/1ps
module tb_voq_pool_buffer;

   localparam int DATA_W  = 16;
   localparam int NUM_OUT = 4;
   localparam int DEPTH   = 8;

   logic                      clk = 1'b0;
   logic                      rst_n = 1'b0;
   logic                      in_valid = 1'b0;
   logic                      in_ready;
   logic [DATA_W-1:0]         in_data = '0;
   logic [1:0]                in_port = '0;
   logic [NUM_OUT-1:0]        deq_grant = '0;
   logic [NUM_OUT-1:0]        head_valid;
   logic [NUM_OUT*DATA_W-1:0] head_data;

   always #5 clk = ~clk;

   voq_pool_buffer #(.DATA_W(DATA_W), .NUM_OUT(NUM_OUT), .DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_port(in_port), .deq_grant(deq_grant),
      .head_valid(head_valid), .head_data(head_data)
   );

   logic [DATA_W-1:0] sb [NUM_OUT][$];
   int  checks = 0;
   int  fails  = 0;
   bit  mon_en = 0;
   bit  done   = 0;
   bit  last_ready;

   function automatic int model_total();
      int t = 0;
      for (int o = 0; o < NUM_OUT; o++) t += sb[o].size();
      return t;
   endfunction

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // driver: applies one cycle of stimulus and updates the scoreboard
   task automatic step(input bit v, input logic [DATA_W-1:0] d, input int p,
                       input logic [NUM_OUT-1:0] g);
      bit exp_ready;
      bit acc;
      @(negedge clk);
      in_valid = v; in_data = d; in_port = 2'(p); deq_grant = g;
      #1;
      exp_ready = (model_total() < DEPTH);
      for (int o = 0; o < NUM_OUT; o++)
         if (g[o] && sb[o].size() > 0) exp_ready = 1;
      chk(in_ready == exp_ready, "R5 in_ready", in_ready, exp_ready);
      last_ready = in_ready;
      acc = v && in_ready;
      @(posedge clk);
      #1;
      for (int o = 0; o < NUM_OUT; o++)
         if (g[o] && sb[o].size() > 0) void'(sb[o].pop_front());
      if (acc) sb[p].push_back(d);
      in_valid = 0; deq_grant = '0;
   endtask

   // monitor: compares every head against the scoreboard between edges
   always @(negedge clk) begin
      if (mon_en) begin
         for (int o = 0; o < NUM_OUT; o++) begin
            chk(head_valid[o] == (sb[o].size() != 0), "R2 R9 head_valid",
                head_valid[o], sb[o].size() != 0);
            if (sb[o].size() != 0)
               chk(head_data[o*DATA_W +: DATA_W] == sb[o][0], "R3 head_data order",
                   head_data[o*DATA_W +: DATA_W], sb[o][0]);
         end
      end
   end

   task automatic drain();
      for (int o = 0; o < NUM_OUT; o++)
         while (sb[o].size() > 0) step(0, '0, 0, NUM_OUT'(1 << o));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      int acc_cnt;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(head_valid == '0, "R1 head_valid after reset", head_valid, 0);
      chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
      rst_n = 1'b1;
      mon_en = 1;

      // burst to one output, then one flit for each output
      step(1, 16'hA001, 2, '0);
      step(1, 16'hA002, 2, '0);
      step(1, 16'hA003, 2, '0);
      step(1, 16'hB001, 0, '0);
      step(1, 16'hC001, 1, '0);
      step(1, 16'hD001, 3, '0);
      chk(head_valid == 4'b1111, "R4 all heads visible", head_valid, 4'hF);

      // grants on output 2 while other outputs keep receiving
      step(1, 16'hB002, 0, 4'b0100);
      step(1, 16'hC002, 1, 4'b0100);
      step(0, '0, 0, 4'b0100);
      chk(head_valid[2] == 1'b0, "R9 queue 2 emptied", head_valid[2], 0);
      drain();

      // whole pool through one output
      for (int i = 0; i < DEPTH; i++) step(1, 16'h0100 + 16'(i), 0, '0);
      step(1, 16'hDEAD, 1, '0);
      chk(last_ready == 1'b0, "R5 full pool stalls", last_ready, 0);
      step(0, '0, 0, 4'b1000);
      chk(last_ready == 1'b0, "R7 empty grant frees nothing", last_ready, 0);
      chk(head_valid == 4'b0001, "R7 queues unchanged", head_valid, 4'b0001);
      step(1, 16'hBEEF, 1, 4'b0001);
      chk(last_ready == 1'b1, "R6 same-cycle reuse", last_ready, 1);
      chk(head_valid[1] == 1'b1, "R6 reused slot queued", head_valid[1], 1);
      drain();

      // refill across all outputs: no leaked or duplicated slot
      acc_cnt = 0;
      for (int i = 0; i < DEPTH + 2; i++) begin
         step(1, 16'h0200 + 16'(i), i % NUM_OUT, '0);
         if (last_ready) acc_cnt++;
      end
      chk(acc_cnt == DEPTH, "R8 refill accepts DEPTH", acc_cnt, DEPTH);
      drain();
      step(0, '0, 0, '0);

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule